// File: doc/BRIEF.md
# Parallel Printer Byte Handshake Source

This block is the host side of a byte-wide parallel printer link in compatibility (forward-only) mode. A byte arrives on a valid/ready interface. The block then runs the full handshake for that byte:

- It samples the printer's active-low fault line. If a fault is signalled, it stops and reports it.
- It waits for the printer's busy line to fall.
- It places the byte on the eight data lines and holds it through a setup interval.
- It pulses the active-low strobe.
- It holds the data for a further interval.
- It waits for the printer to pulse its active-low acknowledge and to release busy.

All three printer inputs pass through a clock-domain synchronizer before the block uses them. The acknowledge is recognised on its falling edge.

Two watchdogs guard the sequence, and each has its own limit in clock cycles. The first catches an acknowledge that never comes. The second catches a busy line that stays high, either before the strobe or after the acknowledge. A fault or a timeout sends the block back to idle. The matching status flag stays set until the next byte is accepted. A one-cycle completion pulse marks each byte that finished the handshake cleanly.

Top module: `lp_hs_source`

## Requirements
- R1: After reset the strobe output is high, the ready output is high, the data output is zero, and the completion pulse and all three status flags are low.
- R2: A byte is taken only when ready and valid are both high. Ready stays low until that byte's handshake ends. The taken byte is on the data output when the strobe falls, and it stays unchanged while the strobe is low and for at least HOLD_CYC cycles after the strobe rises.
- R3: If the synchronized fault input is low (active) when the block checks it right after accepting a byte, the block raises the fault flag, never lowers the strobe, and returns to ready.
- R4: The strobe falls only while the busy input is low, and at least SETUP_CYC cycles after busy was last seen going low.
- R5: The strobe stays low for exactly STROBE_CYC clock cycles.
- R6: A byte completes only after a falling edge of the acknowledge input has been seen after the strobe fell, and after busy has then been seen low. Completion is a single-cycle pulse with all status flags low, issued once busy has dropped.
- R7: If no acknowledge falling edge is seen within ACK_LIMIT cycles of waiting after the hold interval, the acknowledge-timeout flag is set and the block returns to ready.
- R8: If busy stays high for BUSY_LIMIT cycles, the busy-timeout flag is set and the block returns to ready. This applies both while waiting to strobe and while waiting for busy to drop after the acknowledge.
- R9: At most one status flag is high at any time. A flag stays high until the next byte is accepted, and all flags are low from the cycle after that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block can take a byte (idle) |
| in_byte | input | 8 | Offered byte |
| prn_data | output | 8 | Data lines to the printer |
| prn_stb_n | output | 1 | Data strobe, active low |
| prn_fault_n | input | 1 | Printer fault, active low |
| prn_busy | input | 1 | Printer busy, active high |
| prn_ack_n | input | 1 | Printer acknowledge pulse, active low |
| st_fault | output | 1 | Last request was refused because of a printer fault |
| st_ack_timeout | output | 1 | Last request ended because no acknowledge arrived |
| st_busy_timeout | output | 1 | Last request ended because busy stayed high |
| xfer_done | output | 1 | One-cycle pulse: byte handshake completed |

## Verification
A model receiver is driven with random bytes and random delays: busy before the strobe, the gap from strobe to acknowledge, and how long busy stays high after the acknowledge. The bench checks the byte captured at each strobe edge, the strobe width, the setup and hold intervals, and that completion comes after busy drops. Directed cases separate the other outcomes from one another:
- an acknowledge that lands while the strobe is still low or during the hold interval, against one that comes later;
- a fault present at request time, which must produce no strobe at all;
- busy stuck high before the strobe;
- a missing acknowledge;
- busy stuck high after a valid acknowledge.

The last three must each raise only their own flag. A clean request after a failed one shows whether the flags clear on acceptance.

// File: rtl/lp_hs_pkg.sv
package lp_hs_pkg;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_CHECK,
    HS_WAIT_FREE,
    HS_SETUP,
    HS_STROBE,
    HS_HOLD,
    HS_WAIT_ACK
  } hs_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // True in the last cycle of an interval of 'length' cycles whose count started at zero.
  function automatic logic at_last(input int unsigned count, input int unsigned length);
    return (length == 0) || (count + 1 >= length);
  endfunction

endpackage

// File: rtl/lp_hs_sync.sv
module lp_hs_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/lp_hs_timer.sv
module lp_hs_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          count <= '0;
    else if (clr)                        count <= '0;
    else if (run && count != {W{1'b1}})  count <= count + 1'b1;
  end

endmodule

// File: rtl/lp_hs_source.sv
module lp_hs_source
  import lp_hs_pkg::*;
#(
  parameter int unsigned SETUP_CYC   = 2,
  parameter int unsigned STROBE_CYC  = 3,
  parameter int unsigned HOLD_CYC    = 2,
  parameter int unsigned ACK_LIMIT   = 40,
  parameter int unsigned BUSY_LIMIT  = 80,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  output logic [7:0] prn_data,
  output logic       prn_stb_n,
  input  logic       prn_fault_n,
  input  logic       prn_busy,
  input  logic       prn_ack_n,
  output logic       st_fault,
  output logic       st_ack_timeout,
  output logic       st_busy_timeout,
  output logic       xfer_done
);

  localparam int unsigned CNT_MAX = max2(max2(ACK_LIMIT, BUSY_LIMIT),
                                         max2(SETUP_CYC, max2(STROBE_CYC, HOLD_CYC)));
  localparam int unsigned CW = $clog2(CNT_MAX + 1);

  hs_state_t state_q, state_d;

  // synchronized printer inputs: {fault_n, busy, ack_n}
  logic [2:0] line_s;
  logic fault_ok_s, busy_s, ack_s, ack_prev;
  lp_hs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({prn_fault_n, prn_busy, prn_ack_n}),
    .dout(line_s)
  );
  assign fault_ok_s = line_s[2];
  assign busy_s     = line_s[1];
  assign ack_s      = line_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_prev <= 1'b1;
    else        ack_prev <= ack_s;
  end

  // named internal events
  logic ack_fall, ev_accept, ev_fault, ev_ack_to, ev_busy_to, ev_done;
  logic ack_seen, busy_run, ack_run, phase_clr;
  logic [CW-1:0] phase_cnt, busy_cnt, ack_cnt;

  assign ack_fall  = ack_prev && !ack_s;
  assign in_ready  = (state_q == HS_IDLE);
  assign ev_accept = in_valid && in_ready;
  assign busy_run  = busy_s && ((state_q == HS_WAIT_FREE) ||
                                (state_q == HS_WAIT_ACK && ack_seen));
  assign ack_run   = (state_q == HS_WAIT_ACK) && !ack_seen;
  assign phase_clr = (state_d != state_q);

  lp_hs_timer #(.W(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(phase_clr), .run(1'b1), .count(phase_cnt));
  lp_hs_timer #(.W(CW)) u_busy_wd (
    .clk(clk), .rst_n(rst_n), .clr(!busy_run), .run(busy_run), .count(busy_cnt));
  lp_hs_timer #(.W(CW)) u_ack_wd (
    .clk(clk), .rst_n(rst_n), .clr(!ack_run), .run(ack_run), .count(ack_cnt));

  logic busy_expired, ack_expired;
  assign busy_expired = busy_run && at_last(32'(busy_cnt), BUSY_LIMIT);
  assign ack_expired  = ack_run  && at_last(32'(ack_cnt), ACK_LIMIT);

  always_comb begin
    state_d    = state_q;
    ev_fault   = 1'b0;
    ev_ack_to  = 1'b0;
    ev_busy_to = 1'b0;
    ev_done    = 1'b0;
    case (state_q)
      HS_IDLE:      if (ev_accept) state_d = HS_CHECK;
      HS_CHECK:     if (!fault_ok_s) begin
                      ev_fault = 1'b1;
                      state_d  = HS_IDLE;
                    end else begin
                      state_d  = HS_WAIT_FREE;
                    end
      HS_WAIT_FREE: if (!busy_s) state_d = HS_SETUP;
                    else if (busy_expired) begin
                      ev_busy_to = 1'b1;
                      state_d    = HS_IDLE;
                    end
      HS_SETUP:     if (at_last(32'(phase_cnt), SETUP_CYC))  state_d = HS_STROBE;
      HS_STROBE:    if (at_last(32'(phase_cnt), STROBE_CYC)) state_d = HS_HOLD;
      HS_HOLD:      if (at_last(32'(phase_cnt), HOLD_CYC))   state_d = HS_WAIT_ACK;
      HS_WAIT_ACK:  if (ack_seen && !busy_s) begin
                      ev_done = 1'b1;
                      state_d = HS_IDLE;
                    end else if (ack_expired) begin
                      ev_ack_to = 1'b1;
                      state_d   = HS_IDLE;
                    end else if (busy_expired) begin
                      ev_busy_to = 1'b1;
                      state_d    = HS_IDLE;
                    end
      default:      state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q         <= HS_IDLE;
      prn_data        <= '0;
      ack_seen        <= 1'b0;
      st_fault        <= 1'b0;
      st_ack_timeout  <= 1'b0;
      st_busy_timeout <= 1'b0;
      xfer_done       <= 1'b0;
    end else begin
      state_q   <= state_d;
      xfer_done <= ev_done;
      if (ev_accept) begin
        prn_data        <= in_byte;
        ack_seen        <= 1'b0;
        st_fault        <= 1'b0;
        st_ack_timeout  <= 1'b0;
        st_busy_timeout <= 1'b0;
      end else begin
        if (ack_fall && (state_q == HS_STROBE || state_q == HS_HOLD ||
                         state_q == HS_WAIT_ACK))
          ack_seen <= 1'b1;
        if (ev_fault)   st_fault        <= 1'b1;
        if (ev_ack_to)  st_ack_timeout  <= 1'b1;
        if (ev_busy_to) st_busy_timeout <= 1'b1;
      end
    end
  end

  assign prn_stb_n = (state_q != HS_STROBE);

endmodule

// File: rtl/lp_hs_source_chk.sv
module lp_hs_source_chk #(
  parameter int unsigned STROBE_CYC = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       prn_stb_n,
  input logic [7:0] prn_data,
  input logic       st_fault,
  input logic       st_ack_timeout,
  input logic       st_busy_timeout,
  input logic       xfer_done,
  input logic       ev_accept,
  input logic       ack_seen
);

  int unsigned low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= 0;
    else if (!prn_stb_n) low_cnt <= low_cnt + 1;
    else                 low_cnt <= 0;
  end

  assert_ready_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !prn_stb_n |-> !in_ready);

  assert_data_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !prn_stb_n |-> $stable(prn_data));

  assert_fault_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_fault |-> prn_stb_n);

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prn_stb_n) |-> low_cnt == STROBE_CYC);

  assert_done_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (ack_seen && in_ready && !st_fault && !st_ack_timeout && !st_busy_timeout));

  assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_fault, st_ack_timeout, st_busy_timeout}));

  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !(st_fault || st_ack_timeout || st_busy_timeout));

endmodule

bind lp_hs_source lp_hs_source_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .prn_stb_n(prn_stb_n),
  .prn_data(prn_data), .st_fault(st_fault), .st_ack_timeout(st_ack_timeout),
  .st_busy_timeout(st_busy_timeout), .xfer_done(xfer_done),
  .ev_accept(ev_accept), .ack_seen(ack_seen)
);

// File: tb/lp_hs_source_test.sv
module lp_hs_source_test;

  localparam int SETUP_CYC  = 2;
  localparam int STROBE_CYC = 3;
  localparam int HOLD_CYC   = 2;
  localparam int ACK_LIMIT  = 40;
  localparam int BUSY_LIMIT = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_byte = 8'h00;
  logic [7:0] prn_data;
  logic prn_stb_n;
  logic rx_fault_n = 1'b1;
  logic rx_busy = 1'b0;
  logic rx_ack_n = 1'b1;
  logic st_fault, st_ack_timeout, st_busy_timeout, xfer_done;

  always #10 clk = ~clk;

  lp_hs_source #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC),
                 .ACK_LIMIT(ACK_LIMIT), .BUSY_LIMIT(BUSY_LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .prn_data(prn_data), .prn_stb_n(prn_stb_n),
    .prn_fault_n(rx_fault_n), .prn_busy(rx_busy), .prn_ack_n(rx_ack_n),
    .st_fault(st_fault), .st_ack_timeout(st_ack_timeout),
    .st_busy_timeout(st_busy_timeout), .xfer_done(xfer_done));

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // A delay set is expected to complete cleanly when every wait stays inside its watchdog.
  function automatic bit expect_ok(input int pre, input int ackdly, input int post);
    return (pre + 4 < BUSY_LIMIT) && (ackdly + 4 < ACK_LIMIT) && (post + 4 < BUSY_LIMIT);
  endfunction

  // strobe monitor, sampling at the falling clock edge
  logic [7:0] exp_byte = 8'h00;
  logic [7:0] cap = 8'h00;
  logic prev_stb = 1'b1;
  int n_falls = 0, fall_cyc = 0, low_cnt = 0, hold_left = 0;
  int free_cyc = 0, drop_cyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stb && !prn_stb_n) begin
        n_falls++;
        fall_cyc = cyc;
        cap = prn_data;
        low_cnt = 1;
        check(prn_data == exp_byte, "R2 data at strobe fall", prn_data, exp_byte);
        check(!rx_busy, "R4 busy low at strobe fall", rx_busy, 0);
        check(cyc - free_cyc >= SETUP_CYC, "R4 setup cycles", cyc - free_cyc, SETUP_CYC);
      end else if (!prn_stb_n) begin
        low_cnt++;
        if (prn_data != cap) check(0, "R2 data moved during strobe", prn_data, cap);
      end
      if (!prev_stb && prn_stb_n) begin
        check(low_cnt == STROBE_CYC, "R5 strobe width", low_cnt, STROBE_CYC);
        hold_left = HOLD_CYC + 1;
      end
      if (hold_left > 0 && prn_stb_n) begin
        if (prn_data != cap) check(0, "R2 data moved during hold", prn_data, cap);
        hold_left--;
      end
      prev_stb = prn_stb_n;
    end
  end

  task automatic step();
    @(posedge clk);
    #4;
  endtask

  task automatic rx(input int f0, input int pre, input int ackdly, input int post,
                    input bit do_ack, input bit stay_busy);
    int waited;
    if (pre > 0) begin
      rx_busy = 1'b1;
      repeat (pre) step();
      rx_busy = 1'b0;
    end
    free_cyc = cyc;
    waited = 0;
    while (n_falls == f0 && waited < 300) begin
      step();
      waited++;
    end
    if (n_falls == f0) return;
    rx_busy = 1'b1;
    repeat (ackdly) step();
    if (do_ack) begin
      rx_ack_n = 1'b0;
      repeat (2) step();
      rx_ack_n = 1'b1;
    end
    if (stay_busy) return;
    repeat (post) step();
    rx_busy = 1'b0;
    drop_cyc = cyc;
  endtask

  int acc_cyc = 0, end_cyc = 0, falls_in = 0;
  bit r_done = 0, r_fault = 0, r_ackto = 0, r_busyto = 0, r_flags_after_acc = 0;

  task automatic send(input logic [7:0] b, input int pre, input int ackdly, input int post,
                      input bit do_ack, input bit stay_busy);
    int f0;
    int waited;
    f0 = n_falls;
    exp_byte = b;
    fork
      begin
        while (!in_ready) step();
        in_valid = 1'b1;
        in_byte = b;
        step();
        in_valid = 1'b0;
        in_byte = ~b;
        acc_cyc = cyc;
        r_flags_after_acc = st_fault | st_ack_timeout | st_busy_timeout;
        waited = 0;
        while (!in_ready && waited < 2000) begin
          step();
          waited++;
        end
        end_cyc = cyc;
        r_done = xfer_done;
        r_fault = st_fault;
        r_ackto = st_ack_timeout;
        r_busyto = st_busy_timeout;
      end
      rx(f0, pre, ackdly, post, do_ack, stay_busy);
    join
    falls_in = n_falls - f0;
    rx_busy = 1'b0;
    rx_ack_n = 1'b1;
    repeat (4) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check(prn_stb_n == 1'b1, "R1 strobe idle", prn_stb_n, 1);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    check(prn_data == 8'h00, "R1 data zero", prn_data, 0);
    check({st_fault, st_ack_timeout, st_busy_timeout, xfer_done} == 4'b0,
          "R1 flags low", {st_fault, st_ack_timeout, st_busy_timeout, xfer_done}, 0);

    // R2 R4 R6 plain transfer with busy before strobe and busy after ack
    send(8'hA5, 5, 3, 6, 1'b1, 1'b0);
    check(falls_in == 1, "R2 one strobe per byte", falls_in, 1);
    check(r_done, "R6 done pulse", r_done, 1);
    check(end_cyc > drop_cyc, "R6 done after busy drop", end_cyc, drop_cyc + 1);

    // R6 ack arriving while strobe or hold is still running
    send(8'h3C, 0, 0, 0, 1'b1, 1'b0);
    check(r_done && !r_ackto, "R6 early ack completes", r_done, 1);

    // R6 ack seen but busy held long (still below the limit): completion waits for busy
    send(8'h0F, 0, 2, 50, 1'b1, 1'b0);
    check(r_done, "R6 done after long busy", r_done, 1);
    check(end_cyc > drop_cyc, "R6 no done while busy high", end_cyc, drop_cyc + 1);

    // R3 fault at request time
    rx_fault_n = 1'b0;
    repeat (4) step();
    send(8'h77, 0, 2, 2, 1'b1, 1'b0);
    check(r_fault, "R3 fault flag", r_fault, 1);
    check(falls_in == 0, "R3 no strobe on fault", falls_in, 0);
    check(!r_done, "R3 no done on fault", r_done, 0);
    check(in_ready, "R3 back to ready", in_ready, 1);
    check(st_fault, "R9 fault flag held", st_fault, 1);
    rx_fault_n = 1'b1;
    repeat (4) step();

    // R9 flags cleared by the next accepted request
    send(8'h81, 2, 2, 2, 1'b1, 1'b0);
    check(!r_flags_after_acc, "R9 flags clear after accept", r_flags_after_acc, 0);
    check(r_done && !r_fault, "R9 clean request after fault", r_done, 1);

    // R8 busy stuck before strobe
    send(8'h55, BUSY_LIMIT + 30, 0, 0, 1'b1, 1'b0);
    check(r_busyto && !r_ackto && !r_fault, "R8 busy timeout before strobe", r_busyto, 1);
    check(falls_in == 0, "R8 no strobe while busy", falls_in, 0);
    check(end_cyc - acc_cyc >= BUSY_LIMIT, "R8 waited full limit", end_cyc - acc_cyc, BUSY_LIMIT);

    // R7 acknowledge never comes
    send(8'hC3, 0, 0, 0, 1'b0, 1'b1);
    check(r_ackto && !r_busyto && !r_done, "R7 ack timeout", r_ackto, 1);
    check(end_cyc - fall_cyc >= ACK_LIMIT, "R7 waited full limit", end_cyc - fall_cyc, ACK_LIMIT);
    check(st_ack_timeout, "R9 ack flag held", st_ack_timeout, 1);

    // R8 ack arrives but busy never drops
    send(8'h18, 0, 3, 0, 1'b1, 1'b1);
    check(r_busyto && !r_ackto && !r_done, "R8 busy timeout after ack", r_busyto, 1);

    // random transfers
    for (int i = 0; i < 30; i++) begin
      int pre, ackdly, post;
      logic [7:0] b;
      b = 8'($urandom_range(0, 255));
      pre = $urandom_range(0, 12);
      ackdly = $urandom_range(0, 10);
      post = $urandom_range(0, 12);
      send(b, pre, ackdly, post, 1'b1, 1'b0);
      check(r_done == expect_ok(pre, ackdly, post), "R6 random completion",
            r_done, expect_ok(pre, ackdly, post));
      check(!(r_fault | r_ackto | r_busyto), "R9 random no flags",
            {r_fault, r_ackto, r_busyto}, 0);
      check(falls_in == 1, "R2 random one strobe", falls_in, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule